// File: doc/BRIEF.md
# Unaligned Vector Move Decode-Execute Unit

This block decodes and executes one packed-integer vector move per request. The caller presents the bytes of the instruction already split out: the mandatory prefix, the escape byte, the opcode, the operand-selector byte (mode, reg and rm fields), and, for the extended-prefix encoding, the operand-size bit and the reserved source-register field. The unit reads its source from a 256-bit vector register file or from memory. It writes the result back to a register or stores it to memory, and it applies the upper-lane rule of the encoding that was used.

Three encodings are supported. The legacy form moves 128 bits and leaves the upper lane of a register destination untouched. The short extended form moves 128 bits and clears the upper lane. The wide extended form moves all 256 bits. A memory operand may sit at any byte address. An optional alignment check, fixed at build time, can turn an access that is not 8-byte aligned into a fault while the run-time checking conditions hold. Faults are decided before any side effect, and every instruction ends with a one-cycle completion pulse that carries its fault flags.

Top module: `vmov_unit`

## Requirements
- R1: Prefix F3h, escape 0Fh and opcode 6Fh select the load form. The register {reg_ext, sel[5:3]} is written from the rm operand: register sel[2:0] when sel[7:6]=11b, otherwise memory at mem_addr_in.
- R2: Opcode 7Fh selects the store form. Register {reg_ext, sel[5:3]} is read and written to the rm operand: register sel[2:0] when sel[7:6]=11b, otherwise memory.
- R3: With enc_ext=0 (legacy), a register destination receives bits 127:0 only, so rf_wr_lane_en=01b and bits 255:128 keep their old value.
- R4: With enc_ext=1 and wide_256=0, a register destination receives bits 127:0 and bits 255:128 become zero (rf_wr_lane_en=11b).
- R5: With enc_ext=1 and wide_256=1, all 256 bits are moved.
- R6: With enc_ext=1 and spare_src other than 1111b, the unit raises fault_ud with done and makes no register write and no memory request. spare_src is ignored when enc_ext=0.
- R7: Any prefix other than F3h, escape other than 0Fh, or opcode other than 6Fh or 7Fh raises fault_ud with no side effect.
- R8: A memory operand at any byte address completes without fault whenever alignment checking is inactive: either the build parameter is 0, or any of align_chk_en, flag_align or priv_lvl=3 is not met.
- R9: With the build parameter set to 1, align_chk_en=1, flag_align=1 and priv_lvl=3, a memory operand whose mem_addr_in[2:0] is not zero raises fault_ac with no side effect. fault_ud takes precedence, and the two flags are never raised together.
- R10: reg_ext supplies bit 3 of the reg-field register index, so registers 8 to 15 can be reached.
- R11: A memory request enables bytes 0 to 15 for the 128-bit forms and bytes 0 to 31 for the wide form. A 128-bit store leaves memory bytes 16 to 31 of the operand unchanged and drives zero on mem_wdata[255:128].
- R12: A register-to-register move or a fault raises done one cycle after start. A memory form issues a one-cycle mem_req in the cycle after start and raises done one cycle after mem_rsp_valid. A register writeback happens only in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction valid; accepted when the unit is idle |
| pfx_byte | input | 8 | Mandatory prefix byte |
| esc_byte | input | 8 | Escape byte |
| opc_byte | input | 8 | Opcode byte |
| sel | input | 8 | Operand-selector byte: mode[7:6], reg[5:3], rm[2:0] |
| enc_ext | input | 1 | 1 = extended-prefix encoding, 0 = legacy |
| wide_256 | input | 1 | Operand-size bit of the extended form |
| spare_src | input | 4 | Reserved source field, must be 1111b in the extended form |
| reg_ext | input | 1 | Extension bit for the reg field |
| mem_addr_in | input | ADDR_W | Effective address of a memory operand |
| align_chk_en | input | 1 | System-level alignment-check enable |
| flag_align | input | 1 | Flag-level alignment-check enable |
| priv_lvl | input | 2 | Current privilege level |
| rf_rd_idx | output | 4 | Register-file read index |
| rf_rd_data | input | VLEN | Register-file read data, same cycle |
| rf_wr_en | output | 1 | Register writeback strobe |
| rf_wr_idx | output | 4 | Writeback register index |
| rf_wr_lane_en | output | VLEN/128 | Per-128-bit-lane write enable |
| rf_wr_data | output | VLEN | Writeback data |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | ADDR_W | Request address, any alignment |
| mem_be | output | VLEN/8 | Byte enables |
| mem_wdata | output | VLEN | Store data |
| mem_rsp_valid | input | 1 | Memory response, at least one cycle after mem_req |
| mem_rdata | input | VLEN | Load data from the request address upward |
| done | output | 1 | One-cycle completion pulse |
| fault_ud | output | 1 | Invalid-opcode fault, valid with done |
| fault_ac | output | 1 | Alignment-check fault, valid with done |

## Verification
The main instance is built with the alignment check enabled and default widths. In that build, misaligned accesses fault only under all three run-time conditions, and they complete cleanly when any one condition drops. A second instance with the check disabled receives the same misaligned, fully qualified access and must complete without fault_ac. The bench mixes random encodings, directions, register and memory operands, byte offsets and reserved-field values. It predicts the whole register file and memory image after every instruction, which exposes stray upper-lane writes and any side effect of a faulting instruction.

// File: rtl/vmov_pkg.sv
package vmov_pkg;

    localparam int REG_IDX_W = 4;

    typedef enum logic [1:0] {
        ENC_LEGACY = 2'd0,
        ENC_EXT128 = 2'd1,
        ENC_EXT256 = 2'd2
    } enc_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } state_e;

    typedef struct packed {
        logic                 fault_ud;
        logic                 fault_ac;
        logic                 is_store;
        logic                 is_mem;
        enc_e                 enc;
        logic [REG_IDX_W-1:0] rd_idx;
        logic [REG_IDX_W-1:0] wr_idx;
    } dec_t;

endpackage

// File: rtl/vmov_decode.sv
module vmov_decode
    import vmov_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter bit AC_CHECK = 1'b1,
    parameter int AC_GRAN  = 8
) (
    input  logic [7:0]        pfx_byte,
    input  logic [7:0]        esc_byte,
    input  logic [7:0]        opc_byte,
    input  logic [7:0]        sel,
    input  logic              enc_ext,
    input  logic              wide_256,
    input  logic [3:0]        spare_src,
    input  logic              reg_ext,
    input  logic [ADDR_W-1:0] mem_addr_in,
    input  logic              align_chk_en,
    input  logic              flag_align,
    input  logic [1:0]        priv_lvl,
    output dec_t              dec
);
    localparam int AC_LSB = $clog2(AC_GRAN);

    logic                 form_ok;
    logic                 spare_bad;
    logic                 ud;
    logic                 misal;
    logic                 chk_live;
    logic [REG_IDX_W-1:0] reg_idx;
    logic [REG_IDX_W-1:0] rm_idx;

    always_comb begin
        form_ok   = (pfx_byte == 8'hF3) && (esc_byte == 8'h0F) &&
                    ((opc_byte == 8'h6F) || (opc_byte == 8'h7F));
        spare_bad = enc_ext && (spare_src != 4'hF);
        ud        = !form_ok || spare_bad;
        misal     = |mem_addr_in[AC_LSB-1:0];
        chk_live  = AC_CHECK && align_chk_en && flag_align && (priv_lvl == 2'd3);
        reg_idx   = {reg_ext, sel[5:3]};
        rm_idx    = {1'b0, sel[2:0]};

        dec.fault_ud = ud;
        dec.is_mem   = (sel[7:6] != 2'b11);
        dec.fault_ac = !ud && dec.is_mem && chk_live && misal;
        dec.is_store = (opc_byte == 8'h7F);
        if (!enc_ext)      dec.enc = ENC_LEGACY;
        else if (wide_256) dec.enc = ENC_EXT256;
        else               dec.enc = ENC_EXT128;
        dec.rd_idx = dec.is_store ? reg_idx : rm_idx;
        dec.wr_idx = dec.is_store ? rm_idx  : reg_idx;
    end
endmodule

// File: rtl/vmov_lane_fmt.sv
module vmov_lane_fmt
    import vmov_pkg::*;
#(
    parameter int VLEN   = 256,
    parameter int LANE_W = 128
) (
    input  logic [VLEN-1:0]          src,
    input  enc_e                     enc,
    output logic [VLEN-1:0]          data,
    output logic [VLEN/LANE_W-1:0]   lane_en,
    output logic [VLEN/8-1:0]        be
);
    localparam int NL = VLEN / LANE_W;
    localparam int LB = LANE_W / 8;

    for (genvar l = 0; l < NL; l++) begin : g_lane
        if (l == 0) begin : g_low
            assign data[LANE_W-1:0] = src[LANE_W-1:0];
            assign lane_en[0]       = 1'b1;
            assign be[LB-1:0]       = {LB{1'b1}};
        end else begin : g_up
            logic full;
            assign full = (enc == ENC_EXT256);
            assign data[l*LANE_W +: LANE_W] = full ? src[l*LANE_W +: LANE_W] : '0;
            assign lane_en[l]               = (enc != ENC_LEGACY);
            assign be[l*LB +: LB]           = {LB{full}};
        end
    end
endmodule

// File: rtl/vmov_unit.sv
module vmov_unit
    import vmov_pkg::*;
#(
    parameter int VLEN     = 256,
    parameter int LANE_W   = 128,
    parameter int ADDR_W   = 32,
    parameter bit AC_CHECK = 1'b1,
    parameter int AC_GRAN  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [7:0]               pfx_byte,
    input  logic [7:0]               esc_byte,
    input  logic [7:0]               opc_byte,
    input  logic [7:0]               sel,
    input  logic                     enc_ext,
    input  logic                     wide_256,
    input  logic [3:0]               spare_src,
    input  logic                     reg_ext,
    input  logic [ADDR_W-1:0]        mem_addr_in,
    input  logic                     align_chk_en,
    input  logic                     flag_align,
    input  logic [1:0]               priv_lvl,
    output logic [REG_IDX_W-1:0]     rf_rd_idx,
    input  logic [VLEN-1:0]          rf_rd_data,
    output logic                     rf_wr_en,
    output logic [REG_IDX_W-1:0]     rf_wr_idx,
    output logic [VLEN/LANE_W-1:0]   rf_wr_lane_en,
    output logic [VLEN-1:0]          rf_wr_data,
    output logic                     mem_req,
    output logic                     mem_we,
    output logic [ADDR_W-1:0]        mem_addr,
    output logic [VLEN/8-1:0]        mem_be,
    output logic [VLEN-1:0]          mem_wdata,
    input  logic                     mem_rsp_valid,
    input  logic [VLEN-1:0]          mem_rdata,
    output logic                     done,
    output logic                     fault_ud,
    output logic                     fault_ac
);
    localparam int NL = VLEN / LANE_W;
    localparam int NB = VLEN / 8;

    typedef struct packed {
        state_e               st;
        enc_e                 enc;
        logic                 done;
        logic                 fud;
        logic                 fac;
        logic                 wr_en;
        logic [REG_IDX_W-1:0] wr_idx;
        logic [NL-1:0]        lane_en;
        logic [VLEN-1:0]      wdata;
        logic                 mreq;
        logic                 mwe;
        logic [ADDR_W-1:0]    maddr;
        logic [NB-1:0]        be;
    } ctl_t;

    ctl_t q, d;
    dec_t dec;

    logic [VLEN-1:0] fmt_src;
    enc_e            fmt_enc;
    logic [VLEN-1:0] fmt_data;
    logic [NL-1:0]   fmt_lane;
    logic [NB-1:0]   fmt_be;

    vmov_decode #(
        .ADDR_W  (ADDR_W),
        .AC_CHECK(AC_CHECK),
        .AC_GRAN (AC_GRAN)
    ) decode_i (
        .pfx_byte    (pfx_byte),
        .esc_byte    (esc_byte),
        .opc_byte    (opc_byte),
        .sel         (sel),
        .enc_ext     (enc_ext),
        .wide_256    (wide_256),
        .spare_src   (spare_src),
        .reg_ext     (reg_ext),
        .mem_addr_in (mem_addr_in),
        .align_chk_en(align_chk_en),
        .flag_align  (flag_align),
        .priv_lvl    (priv_lvl),
        .dec         (dec)
    );

    // One formatter serves both paths: register/store data while idle,
    // load data while a memory response is awaited.
    always_comb begin
        if (q.st == ST_WAIT) begin
            fmt_src = mem_rdata;
            fmt_enc = q.enc;
        end else begin
            fmt_src = rf_rd_data;
            fmt_enc = dec.enc;
        end
    end

    vmov_lane_fmt #(
        .VLEN  (VLEN),
        .LANE_W(LANE_W)
    ) fmt_i (
        .src    (fmt_src),
        .enc    (fmt_enc),
        .data   (fmt_data),
        .lane_en(fmt_lane),
        .be     (fmt_be)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.fud   = 1'b0;
        d.fac   = 1'b0;
        d.wr_en = 1'b0;
        d.mreq  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    if (dec.fault_ud || dec.fault_ac) begin
                        d.done = 1'b1;
                        d.fud  = dec.fault_ud;
                        d.fac  = dec.fault_ac;
                    end else if (!dec.is_mem) begin
                        d.done    = 1'b1;
                        d.wr_en   = 1'b1;
                        d.wr_idx  = dec.wr_idx;
                        d.lane_en = fmt_lane;
                        d.wdata   = fmt_data;
                    end else begin
                        d.st     = ST_WAIT;
                        d.enc    = dec.enc;
                        d.mreq   = 1'b1;
                        d.mwe    = dec.is_store;
                        d.maddr  = mem_addr_in;
                        d.be     = fmt_be;
                        d.wdata  = fmt_data;
                        d.wr_idx = dec.wr_idx;
                    end
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if (!q.mwe) begin
                        d.wr_en   = 1'b1;
                        d.lane_en = fmt_lane;
                        d.wdata   = fmt_data;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, enc: ENC_LEGACY, default: '0};
        end else begin
            q <= d;
        end
    end

    assign rf_rd_idx     = dec.rd_idx;
    assign rf_wr_en      = q.wr_en;
    assign rf_wr_idx     = q.wr_idx;
    assign rf_wr_lane_en = q.lane_en;
    assign rf_wr_data    = q.wdata;
    assign mem_req       = q.mreq;
    assign mem_we        = q.mwe;
    assign mem_addr      = q.maddr;
    assign mem_be        = q.be;
    assign mem_wdata     = q.wdata;
    assign done          = q.done;
    assign fault_ud      = q.fud;
    assign fault_ac      = q.fac;
endmodule

// File: rtl/vmov_unit_chk.sv
module vmov_unit_chk #(
    parameter int VLEN   = 256,
    parameter int LANE_W = 128
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   done,
    input logic                   fault_ud,
    input logic                   fault_ac,
    input logic                   rf_wr_en,
    input logic [VLEN/LANE_W-1:0] rf_wr_lane_en,
    input logic                   mem_req,
    input logic                   mem_we,
    input logic [VLEN/8-1:0]      mem_be,
    input logic [VLEN-1:0]        mem_wdata,
    input logic                   mem_rsp_valid
);
    localparam int LB = LANE_W / 8;
    localparam int NB = VLEN / 8;

    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             outstanding <= 1'b0;
        else if (mem_req)       outstanding <= 1'b1;
        else if (mem_rsp_valid) outstanding <= 1'b0;
    end

    // R12
    rsp_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding && mem_rsp_valid) |=> done);

    // R12
    wb_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);

    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_ud || fault_ac) |-> (done && !rf_wr_en && !outstanding && !mem_req));

    // R9
    fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_ud, fault_ac}));

    // R11
    be_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_be[0] && (($countones(mem_be) == LB) || ($countones(mem_be) == NB))));

    // R11
    store_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_be[NB-1]) |-> (mem_wdata[VLEN-1:LANE_W] == '0));

    // R3
    low_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> rf_wr_lane_en[0]);
endmodule

bind vmov_unit vmov_unit_chk #(.VLEN(VLEN), .LANE_W(LANE_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .done         (done),
    .fault_ud     (fault_ud),
    .fault_ac     (fault_ac),
    .rf_wr_en     (rf_wr_en),
    .rf_wr_lane_en(rf_wr_lane_en),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_be       (mem_be),
    .mem_wdata    (mem_wdata),
    .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/vmov_unit_tb.sv
module vmov_unit_tb_top;
    localparam int VLEN  = 256;
    localparam int MEMSZ = 320;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        start = 1'b0;
    logic [7:0]  pfx_byte = 8'hF3, esc_byte = 8'h0F, opc_byte = 8'h6F, sel = 8'hC0;
    logic        enc_ext = 1'b0, wide_256 = 1'b0, reg_ext = 1'b0;
    logic [3:0]  spare_src = 4'hF;
    logic [31:0] mem_addr_in = '0;
    logic        align_chk_en = 1'b0, flag_align = 1'b0;
    logic [1:0]  priv_lvl = 2'd0;

    logic [3:0]      rf_rd_idx, rf_wr_idx, n_rd_idx, n_wr_idx;
    logic [VLEN-1:0] rf_rd_data, rf_wr_data, n_rd_data, n_wr_data;
    logic            rf_wr_en, n_wr_en;
    logic [1:0]      rf_wr_lane_en, n_lane_en;
    logic            mem_req, mem_we, n_req, n_we;
    logic [31:0]     mem_addr, n_addr;
    logic [31:0]     mem_be, n_be;
    logic [VLEN-1:0] mem_wdata, n_wdata;
    logic            mem_rsp_valid = 1'b0, n_rsp = 1'b0;
    logic [VLEN-1:0] mem_rdata = '0;
    logic            done, fault_ud, fault_ac, n_done, n_fud, n_fac;

    logic [VLEN-1:0] rf  [16];
    logic [VLEN-1:0] rrf [16];
    logic [7:0]      mem [MEMSZ];
    logic [7:0]      rmem[MEMSZ];

    int checks = 0, fails = 0, cyc = 0;
    logic n_seen = 1'b0, n_fac_seen = 1'b0;

    assign rf_rd_data = rf[rf_rd_idx];
    assign n_rd_data  = rf[n_rd_idx];

    vmov_unit #(.AC_CHECK(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pfx_byte(pfx_byte), .esc_byte(esc_byte),
        .opc_byte(opc_byte), .sel(sel), .enc_ext(enc_ext), .wide_256(wide_256),
        .spare_src(spare_src), .reg_ext(reg_ext), .mem_addr_in(mem_addr_in),
        .align_chk_en(align_chk_en), .flag_align(flag_align), .priv_lvl(priv_lvl),
        .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data), .rf_wr_en(rf_wr_en),
        .rf_wr_idx(rf_wr_idx), .rf_wr_lane_en(rf_wr_lane_en), .rf_wr_data(rf_wr_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
        .done(done), .fault_ud(fault_ud), .fault_ac(fault_ac)
    );

    vmov_unit #(.AC_CHECK(1'b0)) noac_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pfx_byte(pfx_byte), .esc_byte(esc_byte),
        .opc_byte(opc_byte), .sel(sel), .enc_ext(enc_ext), .wide_256(wide_256),
        .spare_src(spare_src), .reg_ext(reg_ext), .mem_addr_in(mem_addr_in),
        .align_chk_en(align_chk_en), .flag_align(flag_align), .priv_lvl(priv_lvl),
        .rf_rd_idx(n_rd_idx), .rf_rd_data(n_rd_data), .rf_wr_en(n_wr_en),
        .rf_wr_idx(n_wr_idx), .rf_wr_lane_en(n_lane_en), .rf_wr_data(n_wr_data),
        .mem_req(n_req), .mem_we(n_we), .mem_addr(n_addr), .mem_be(n_be),
        .mem_wdata(n_wdata), .mem_rsp_valid(n_rsp), .mem_rdata('0),
        .done(n_done), .fault_ud(n_fud), .fault_ac(n_fac)
    );

    // environment: register file, memory with one-cycle response
    always @(posedge clk) begin
        if (rf_wr_en) begin
            if (rf_wr_lane_en[0]) rf[rf_wr_idx][127:0]   <= rf_wr_data[127:0];
            if (rf_wr_lane_en[1]) rf[rf_wr_idx][255:128] <= rf_wr_data[255:128];
        end
        mem_rsp_valid <= mem_req;
        if (mem_req) begin
            for (int b = 0; b < 32; b++) begin
                mem_rdata[b*8 +: 8] <= mem[(mem_addr[8:0] + b) % MEMSZ];
                if (mem_we && mem_be[b]) mem[(mem_addr[8:0] + b) % MEMSZ] <= mem_wdata[b*8 +: 8];
            end
        end
        n_rsp <= n_req;
        if (n_done) begin
            n_seen <= 1'b1;
            if (n_fac) n_fac_seen <= 1'b1;
        end
    end

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] rd_rmem(input int a);
        logic [255:0] v;
        for (int b = 0; b < 32; b++) v[b*8 +: 8] = rmem[(a + b) % MEMSZ];
        return v;
    endfunction

    // writes a value into the reference register file with the encoding's lane rule (R3 R4 R5)
    task automatic ref_reg_write(input int idx, input bit ext, input bit wide, input logic [255:0] v);
        if (!ext)      rrf[idx][127:0] = v[127:0];
        else if (wide) rrf[idx] = v;
        else           rrf[idx] = {128'd0, v[127:0]};
    endtask

    task automatic run(input bit ext, input bit wide, input logic [7:0] pfx, input logic [7:0] esc,
                       input logic [7:0] opc, input logic [7:0] s, input logic [3:0] spare,
                       input bit rx, input int addr, input bit am, input bit fa,
                       input logic [1:0] pl, input string req);
        bit exp_ud, exp_ac, is_mem;
        int lat, reg_i, rm_i, exp_lat;
        logic [255:0] v;
        bit all_ok;
        exp_ud = !(pfx == 8'hF3 && esc == 8'h0F && (opc == 8'h6F || opc == 8'h7F)) ||
                 (ext && spare != 4'hF);
        is_mem = (s[7:6] != 2'b11);
        exp_ac = !exp_ud && is_mem && am && fa && pl == 2'd3 && (addr % 8 != 0);
        reg_i  = {rx, s[5:3]};
        rm_i   = s[2:0];
        if (!exp_ud && !exp_ac) begin
            if (opc == 8'h6F) begin
                v = is_mem ? rd_rmem(addr) : rrf[rm_i];
                ref_reg_write(reg_i, ext, wide, v);
            end else begin
                v = rrf[reg_i];
                if (is_mem) begin
                    for (int b = 0; b < ((ext && wide) ? 32 : 16); b++)
                        rmem[(addr + b) % MEMSZ] = v[b*8 +: 8];
                end else begin
                    ref_reg_write(rm_i, ext, wide, v);
                end
            end
        end
        exp_lat = (is_mem && !exp_ud && !exp_ac) ? 3 : 1;

        enc_ext = ext; wide_256 = wide; pfx_byte = pfx; esc_byte = esc; opc_byte = opc;
        sel = s; spare_src = spare; reg_ext = rx; mem_addr_in = addr;
        align_chk_en = am; flag_align = fa; priv_lvl = pl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1 && lat == exp_lat, "R12", {req, " done latency"}, lat, exp_lat);
        chk(fault_ud == exp_ud, (exp_ud ? "R6/R7" : "R1"), {req, " fault_ud"}, fault_ud, exp_ud);
        chk(fault_ac == exp_ac, (exp_ac ? "R9" : "R8"), {req, " fault_ac"}, fault_ac, exp_ac);
        @(negedge clk);
        all_ok = 1'b1;
        for (int r = 0; r < 16; r++) if (rf[r] !== rrf[r]) begin
            all_ok = 1'b0;
            chk(1'b0, "R2", {req, " register file"}, rf[r], rrf[r]);
        end
        if (all_ok) chk(1'b1, "R2", "", 0, 0);
        all_ok = 1'b1;
        for (int b = 0; b < MEMSZ; b++) if (mem[b] !== rmem[b]) begin
            all_ok = 1'b0;
            chk(1'b0, "R11", {req, " memory"}, mem[b], rmem[b]);
        end
        if (all_ok) chk(1'b1, "R11", "", 0, 0);
    endtask

    initial begin
        logic [255:0] v;
        void'($urandom(32'd20240611));
        for (int r = 0; r < 16; r++) begin
            for (int w = 0; w < 8; w++) v[w*32 +: 32] = $urandom();
            rf[r] = v; rrf[r] = v;
        end
        for (int b = 0; b < MEMSZ; b++) begin
            mem[b] = 8'($urandom()); rmem[b] = mem[b];
        end
        repeat (3) @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0 && rf_wr_en == 1'b0, "R12", "reset state",
            {done, mem_req, rf_wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 legacy register copy keeps upper lane; R1 reg form
        run(0, 0, 8'hF3, 8'h0F, 8'h6F, 8'hC0 | (3 << 3) | 5, 4'h2, 0, 0, 0, 0, 0, "R3 legacy reg load");
        // R4 short extended clears upper lane
        run(1, 0, 8'hF3, 8'h0F, 8'h6F, 8'hC0 | (2 << 3) | 6, 4'hF, 0, 0, 0, 0, 0, "R4 ext128 reg load");
        // R5 wide register store-form copy
        run(1, 1, 8'hF3, 8'h0F, 8'h7F, 8'hC0 | (1 << 3) | 7, 4'hF, 0, 0, 0, 0, 0, "R5 ext256 reg store");
        // R10 reg extension reaches register 12
        run(1, 1, 8'hF3, 8'h0F, 8'h6F, 8'hC0 | (4 << 3) | 2, 4'hF, 1, 0, 0, 0, 0, "R10 reg_ext dest");
        run(0, 0, 8'hF3, 8'h0F, 8'h7F, 8'h00 | (6 << 3), 4'hF, 1, 40, 0, 0, 0, "R10 reg_ext src store");
        // R6 reserved field
        run(1, 0, 8'hF3, 8'h0F, 8'h6F, 8'hC0 | (3 << 3) | 1, 4'hE, 0, 0, 0, 0, 0, "R6 spare reg");
        run(1, 1, 8'hF3, 8'h0F, 8'h7F, 8'h40, 4'h0, 0, 64, 0, 0, 0, "R6 spare mem store");
        // R7 bad prefix / escape / opcode
        run(0, 0, 8'h66, 8'h0F, 8'h6F, 8'hC1, 4'hF, 0, 0, 0, 0, 0, "R7 bad prefix");
        run(0, 0, 8'hF3, 8'h38, 8'h7F, 8'h00, 4'hF, 0, 8, 0, 0, 0, "R7 bad escape");
        run(1, 1, 8'hF3, 8'h0F, 8'h6E, 8'h00, 4'hF, 0, 8, 0, 0, 0, "R7 bad opcode");
        // R8 misaligned accepted when a condition is missing
        run(1, 1, 8'hF3, 8'h0F, 8'h6F, 8'h08, 4'hF, 0, 77, 1, 1, 2, "R8 misaligned pl2");
        run(0, 0, 8'hF3, 8'h0F, 8'h7F, 8'h10, 4'hF, 0, 93, 1, 0, 3, "R8 misaligned noflag");
        run(1, 0, 8'hF3, 8'h0F, 8'h6F, 8'h18, 4'hF, 0, 128, 1, 1, 3, "R8 aligned all set");
        // R9 misaligned with all conditions, both directions
        n_seen = 1'b0; n_fac_seen = 1'b0;
        run(1, 1, 8'hF3, 8'h0F, 8'h7F, 8'h20, 4'hF, 0, 101, 1, 1, 3, "R9 ac store");
        repeat (4) @(negedge clk);
        chk(n_seen && !n_fac_seen, "R8", "check-disabled build on qualified misaligned store",
            {n_seen, n_fac_seen}, 2'b10);
        run(0, 0, 8'hF3, 8'h0F, 8'h6F, 8'h28, 4'hF, 0, 4, 1, 1, 3, "R9 ac load");
        // R11 legacy store leaves bytes 16..31 intact
        run(0, 0, 8'hF3, 8'h0F, 8'h7F, 8'h80 | (5 << 3), 4'h7, 0, 200, 0, 0, 0, "R11 legacy store");
        run(1, 1, 8'hF3, 8'h0F, 8'h7F, 8'h80 | (2 << 3), 4'hF, 0, 3, 0, 0, 0, "R11 wide store");

        for (int i = 0; i < 160; i++) begin
            bit ext, wide, rx, am, fa;
            logic [7:0] pfx, esc, opc, s;
            logic [3:0] spare;
            logic [1:0] pl;
            int a;
            ext   = 1'($urandom_range(0, 1));
            wide  = 1'($urandom_range(0, 1));
            rx    = 1'($urandom_range(0, 1));
            pfx   = ($urandom_range(0, 19) == 0) ? 8'h66 : 8'hF3;
            esc   = ($urandom_range(0, 19) == 0) ? 8'h3A : 8'h0F;
            opc   = ($urandom_range(0, 19) == 0) ? 8'h6E :
                    ($urandom_range(0, 1) == 0 ? 8'h6F : 8'h7F);
            s     = 8'($urandom());
            spare = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
            a     = $urandom_range(0, 255);
            am    = 1'($urandom_range(0, 1));
            fa    = 1'($urandom_range(0, 1));
            pl    = 2'($urandom_range(0, 3));
            run(ext, wide, pfx, esc, opc, s, spare, rx, a, am, fa, pl, "R1 random");
        end

        summary();
        $finish;
    end
endmodule